// File: doc/BRIEF.md
# Request-Triggered Descriptor DMA Sequencer

This block is a small DMA sequencer that sits on a synchronous memory port. A single-cycle pulse on `req` asks it to service one descriptor at a fixed base address. It fetches the descriptor words, performs the move it describes, writes the advanced count and addresses back into the descriptor, and returns to idle. Each move is one of four operations: a copy from memory, a store of an immediate value, a memory-plus-memory sum, or an immediate-plus-memory sum. A move writes either an 8-bit or a 16-bit unit.

The descriptor is five 16-bit words at byte offsets +0 (mode), +2 (count), +4 (source address or immediate), +6 (operand address) and +8 (destination address). The memory port has a fixed one-cycle read latency and never stalls, so it carries no back-pressure. A read issued with `mem_rd` in one cycle returns on `mem_rdata` in the next cycle. A write happens in the cycle that `mem_wr` is high. Single mode moves one unit per request. Burst mode moves every remaining unit on one request and holds `irq_mask` high for the whole run. Multiple mode copies a list of inline address pairs and skips the writeback.

Top module: `reqdma_engine`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `irq_end`, `irq_mask` and `cfg_err` are all low until a request arrives.
- R2: Mode bits [2:1]=0 selects a copy. Mode bit 0 set selects a 16-bit unit. Bit 3 set makes the source advance after each unit and bit 4 set makes the destination advance. After the request, count, source, operand and destination are written back as 16-bit words to offsets +2, +4, +6 and +8. `mem_rd` and `mem_wr` are never high in the same cycle.
- R3: With mode bit 0 clear, only the low byte is stored. `mem_wide` is low, `mem_wdata[15:8]` is zero, the byte above the destination is untouched, and advancing addresses step by 1 instead of 2.
- R4: Mode bits [2:1]=1 stores the source field itself. For an 8-bit unit its high byte is ignored. The source field never advances.
- R5: Mode bits [2:1]=2 stores the word at the source address plus the word at the operand address, wrapped to the unit width. When bit 3 is set, both the source and the operand addresses advance.
- R6: Mode bits [2:1]=3 stores the source field, taken as an immediate, plus the word at the operand address, wrapped to the unit width. Neither the source field nor the operand field advances.
- R7: A descriptor with count zero performs no data write, no writeback and no end interrupt.
- R8: In single mode (bit 5 clear), each request moves one unit and decrements the count by one. When mode bit 6 is set and the count reaches zero, `irq_end` pulses for exactly one cycle.
- R9: With mode bit 5 set, one request moves all remaining units. `irq_mask` is high from the cycle after the mode word is read until the last writeback cycle, and `irq_end` is never high while `irq_mask` is high.
- R10: Mode bit 7 selects multiple mode. Bits [10:8] give N, from 1 to 7 copies per request, and the pairs (source, destination) sit at +4/+6, +8/+10 and onward. Add, burst and end-interrupt bits are ignored, and there is no writeback.
- R11: Multiple mode with N=0 pulses `cfg_err` for one cycle and performs no write.
- R12: A request that arrives while the engine is busy is held and is serviced after the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_wide | output | 1 | Write width: 1 writes two bytes, 0 writes the low byte only |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| irq_end | output | 1 | End-of-transfer interrupt pulse |
| irq_mask | output | 1 | Interrupt hold-off while a burst runs |
| cfg_err | output | 1 | Pulse for an illegal multiple-transfer count |

## Verification
A scoreboard expects every memory write in order, both data writes and descriptor writebacks. It is fed with copy, immediate, memory-plus-memory and immediate-plus-memory descriptors at both unit widths. This separates the adder path, the byte masking and the rules on which address advances: a wrong increment shows up as a wrong address in the next write or in the written-back field. Sums chosen to overflow separate wrap-around from carry leakage into the high byte. Burst, multiple, zero-count and illegal-N descriptors, plus a request raised while busy, tell apart the request-level sequencing. They are checked through the number of writes, the number of `irq_end` and `cfg_err` pulses, and the number of cycles `irq_mask` is high.

// File: rtl/reqdma_pkg.sv
package reqdma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DM, ST_DC, ST_DS, ST_DO, ST_DD, ST_DX,
    ST_MA, ST_MB, ST_MC, ST_R1, ST_R2, ST_R3, ST_WR, ST_WB
  } st_e;

  typedef enum logic [1:0] {OP_COPY, OP_IMM, OP_ADDMM, OP_ADDIM} op_e;

  typedef struct packed {
    logic [2:0] mult_n;
    logic       mult;
    logic       irq_en;
    logic       burst;
    logic       dst_inc;
    logic       src_inc;
    op_e        op;
    logic       wide;
  } mode_t;
endpackage

// File: rtl/reqdma_pend.sv
module reqdma_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic take_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= (pend_o && !take_i) || req_i;
  end
endmodule

// File: rtl/reqdma_step.sv
module reqdma_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP_W = AW'(2);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  assign addr_o = en_i ? addr_i + (wide_i ? STEP_W : STEP_B) : addr_i;
endmodule

// File: rtl/reqdma_alu.sv
module reqdma_alu #(
  parameter int DW = 16
) (
  input  logic          wide_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  localparam int HW = DW / 2;
  logic [DW-1:0] full;
  logic [HW-1:0] half;
  assign full = a_i + b_i;
  assign half = a_i[HW-1:0] + b_i[HW-1:0];
  assign y_o  = wide_i ? full : {{(DW-HW){1'b0}}, half};
endmodule

// File: rtl/reqdma_engine.sv
module reqdma_engine
  import reqdma_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] DESC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          mem_wide,
  input  logic [15:0]   mem_rdata,
  output logic          irq_end,
  output logic          irq_mask,
  output logic          cfg_err
);
  localparam int            DW     = 16;
  localparam int            MW     = $bits(mode_t);
  localparam logic [AW-1:0] A_CNT  = DESC_BASE + AW'(2);
  localparam logic [AW-1:0] A_SRC  = DESC_BASE + AW'(4);
  localparam logic [AW-1:0] A_OPD  = DESC_BASE + AW'(6);
  localparam logic [AW-1:0] A_DST  = DESC_BASE + AW'(8);
  localparam logic [AW-1:0] PAIR_W = AW'(4);

  st_e           st;
  mode_t         md;
  logic [DW-1:0] cnt, src_r, acc;
  logic [AW-1:0] opd, dst, ptr;
  logic [2:0]    left;
  logic [1:0]    wbi;
  logic          pend, take;
  op_e           opx;
  logic          burst_x, irq_x;
  logic [DW-1:0] alu_a, alu_b, alu_y;
  logic [AW-1:0] a_cur [3];
  logic [AW-1:0] a_nxt [3];
  logic          a_en  [3];

  assign opx     = md.mult ? OP_COPY : md.op;
  assign burst_x = md.burst && !md.mult;
  assign irq_x   = md.irq_en && !md.mult;
  assign take    = (st == ST_IDLE) && pend;

  reqdma_pend u_pend (.clk(clk), .rst_n(rst_n), .req_i(req), .take_i(take), .pend_o(pend));

  assign a_cur[0] = src_r[AW-1:0];
  assign a_cur[1] = opd;
  assign a_cur[2] = dst;
  assign a_en[0]  = md.src_inc && (opx == OP_COPY || opx == OP_ADDMM);
  assign a_en[1]  = md.src_inc && (opx == OP_ADDMM);
  assign a_en[2]  = md.dst_inc;

  for (genvar g = 0; g < 3; g++) begin : g_step
    reqdma_step #(.AW(AW)) u_step (
      .addr_i(a_cur[g]), .en_i(a_en[g]), .wide_i(md.wide), .addr_o(a_nxt[g])
    );
  end

  always_comb begin
    alu_a = mem_rdata;
    alu_b = '0;
    if (st == ST_R1) alu_a = src_r;
    if (st == ST_R3) begin
      alu_a = acc;
      alu_b = mem_rdata;
    end
    if (st == ST_R2 && opx == OP_ADDIM) alu_b = src_r;
  end

  reqdma_alu #(.DW(DW)) u_alu (.wide_i(md.wide), .a_i(alu_a), .b_i(alu_b), .y_o(alu_y));

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wide  = (st == ST_WR) ? md.wide : 1'b1;
    unique case (st)
      ST_DM: begin mem_rd = 1'b1; mem_addr = DESC_BASE; end
      ST_DC: begin mem_rd = 1'b1; mem_addr = A_CNT; end
      ST_DS: begin mem_rd = 1'b1; mem_addr = A_SRC; end
      ST_DO: begin mem_rd = 1'b1; mem_addr = A_OPD; end
      ST_DD: begin mem_rd = 1'b1; mem_addr = A_DST; end
      ST_MA: begin mem_rd = 1'b1; mem_addr = ptr; end
      ST_MB: begin mem_rd = 1'b1; mem_addr = ptr + AW'(2); end
      ST_R1: if (opx != OP_IMM) begin
        mem_rd   = 1'b1;
        mem_addr = (opx == OP_ADDIM) ? opd : src_r[AW-1:0];
      end
      ST_R2: if (opx == OP_ADDMM) begin mem_rd = 1'b1; mem_addr = opd; end
      ST_WR: begin mem_wr = 1'b1; mem_addr = dst; mem_wdata = acc; end
      ST_WB: begin
        mem_wr   = 1'b1;
        mem_addr = A_CNT + AW'({wbi, 1'b0});
        case (wbi)
          2'd0:    mem_wdata = cnt;
          2'd1:    mem_wdata = src_r;
          2'd2:    mem_wdata = DW'(opd);
          default: mem_wdata = DW'(dst);
        endcase
      end
      default: ;
    endcase
  end

  assign irq_mask = burst_x && !(st inside {ST_IDLE, ST_DM, ST_DC});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      md      <= '0;
      cnt     <= '0;
      src_r   <= '0;
      acc     <= '0;
      opd     <= '0;
      dst     <= '0;
      ptr     <= '0;
      left    <= '0;
      wbi     <= '0;
      irq_end <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      irq_end <= 1'b0;
      cfg_err <= 1'b0;
      unique case (st)
        ST_IDLE: if (pend) st <= ST_DM;
        ST_DM:   st <= ST_DC;
        ST_DC:   begin md <= mode_t'(mem_rdata[MW-1:0]); st <= ST_DS; end
        ST_DS:   begin cnt <= mem_rdata; st <= ST_DO; end
        ST_DO:   begin src_r <= mem_rdata; st <= ST_DD; end
        ST_DD:   begin opd <= mem_rdata[AW-1:0]; st <= ST_DX; end
        ST_DX: begin
          dst <= mem_rdata[AW-1:0];
          if (md.mult) begin
            if (md.mult_n == 3'd0) begin
              cfg_err <= 1'b1;
              st      <= ST_IDLE;
            end else begin
              left <= md.mult_n;
              ptr  <= A_SRC;
              st   <= ST_MA;
            end
          end else if (cnt == '0) st <= ST_IDLE;
          else                    st <= ST_R1;
        end
        ST_MA: st <= ST_MB;
        ST_MB: begin src_r <= mem_rdata; st <= ST_MC; end
        ST_MC: begin dst <= mem_rdata[AW-1:0]; st <= ST_R1; end
        ST_R1: if (opx == OP_IMM) begin acc <= alu_y; st <= ST_WR; end
               else st <= ST_R2;
        ST_R2: begin
          acc <= alu_y;
          st  <= (opx == OP_ADDMM) ? ST_R3 : ST_WR;
        end
        ST_R3: begin acc <= alu_y; st <= ST_WR; end
        ST_WR: begin
          src_r <= DW'(a_nxt[0]);
          opd   <= a_nxt[1];
          dst   <= a_nxt[2];
          if (md.mult) begin
            left <= left - 3'd1;
            ptr  <= ptr + PAIR_W;
            st   <= (left == 3'd1) ? ST_IDLE : ST_MA;
          end else begin
            cnt <= cnt - DW'(1);
            wbi <= '0;
            st  <= (burst_x && cnt != DW'(1)) ? ST_R1 : ST_WB;
          end
        end
        ST_WB: begin
          wbi <= wbi + 2'd1;
          if (wbi == 2'd3) begin
            irq_end <= irq_x && (cnt == '0);
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reqdma_chk.sv
module reqdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        mem_wide,
  input logic [15:0] mem_wdata,
  input logic        irq_end,
  input logic        irq_mask,
  input logic        cfg_err
);
  // R2: one port access per cycle
  a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R3: narrow writes carry a zero high byte
  a_r3_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wide) |-> (mem_wdata[15:8] == 8'h00));
  // R8: end interrupt is a single-cycle pulse
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |=> !irq_end);
  // R9: no end interrupt while interrupts are held off
  a_r9_irq_outside_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> !irq_mask);
  // R11: configuration error is a single-cycle pulse with no write
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);
  a_r11_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mem_wr);
endmodule

bind reqdma_engine reqdma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wide(mem_wide), .mem_wdata(mem_wdata), .irq_end(irq_end),
  .irq_mask(irq_mask), .cfg_err(cfg_err)
);

// File: tb/reqdma_engine_tb.sv
module reqdma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        mem_rd, mem_wr, mem_wide, irq_end, irq_mask, cfg_err;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [7:0]  mem [0:1023];
  logic [32:0] expq [$];
  int checks = 0, errors = 0;
  int n_irq = 0, n_err = 0, n_mask = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reqdma_engine #(.AW(16), .DESC_BASE(16'h0000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wide(mem_wide),
    .mem_rdata(mem_rdata), .irq_end(irq_end), .irq_mask(irq_mask),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= {mem[10'(mem_addr + 16'd1)], mem[mem_addr[9:0]]};
    if (mem_wr) begin
      mem[mem_addr[9:0]] <= mem_wdata[7:0];
      if (mem_wide) mem[10'(mem_addr + 16'd1)] <= mem_wdata[15:8];
    end
  end

  // monitor: pops expected writes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_end)  n_irq++;
      if (cfg_err)  n_err++;
      if (irq_mask) n_mask++;
      if (mem_wr) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R2/R7: unexpected write addr=%h data=%h expected none", mem_addr, mem_wdata);
        end else begin
          logic [32:0] e;
          e = expq.pop_front();
          if (e != {mem_wide, mem_addr, mem_wdata}) begin
            errors++;
            $display("FAIL R2: write got wide=%0b addr=%h data=%h expected wide=%0b addr=%h data=%h",
                     mem_wide, mem_addr, mem_wdata, e[32], e[31:16], e[15:0]);
          end
        end
      end
    end
  end

  task automatic put_w(input logic [15:0] a, input logic [15:0] v);
    mem[a[9:0]]       = v[7:0];
    mem[10'(a + 16'd1)] = v[15:8];
  endtask

  task automatic set_desc(input logic [15:0] md, input logic [15:0] c,
                          input logic [15:0] s, input logic [15:0] o, input logic [15:0] d);
    put_w(16'h0, md); put_w(16'h2, c); put_w(16'h4, s); put_w(16'h6, o); put_w(16'h8, d);
  endtask

  task automatic exp_w(input logic w, input logic [15:0] a, input logic [15:0] d);
    expq.push_back({w, a, d});
  endtask

  task automatic exp_wb(input logic [15:0] c, input logic [15:0] s,
                        input logic [15:0] o, input logic [15:0] d);
    exp_w(1'b1, 16'h2, c); exp_w(1'b1, 16'h4, s); exp_w(1'b1, 16'h6, o); exp_w(1'b1, 16'h8, d);
  endtask

  task automatic fire();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic drained(input string tag);
    chk(tag, expq.size(), 0);
    expq.delete();
  endtask

  task automatic clr();
    n_irq = 0; n_err = 0; n_mask = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    settle(3);
    // R1: reset state
    chk("R1 mem_rd", int'(mem_rd), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    chk("R1 irq_end", int'(irq_end), 0);
    chk("R1 irq_mask", int'(irq_mask), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    settle(2);

    // R2 R8 R12: 16-bit copy, both advance, count 2, irq enabled; second request while busy
    clr();
    set_desc(16'h0059, 16'd2, 16'h0200, 16'h0000, 16'h0100);
    put_w(16'h0200, 16'h1234); put_w(16'h0202, 16'hBEEF);
    exp_w(1'b1, 16'h0100, 16'h1234); exp_wb(16'd1, 16'h0202, 16'h0000, 16'h0102);
    exp_w(1'b1, 16'h0102, 16'hBEEF); exp_wb(16'd0, 16'h0204, 16'h0000, 16'h0104);
    fire(); settle(3); fire();
    settle(60);
    drained("R12 pending request serviced");
    chk("R8 irq_end pulses at count zero", n_irq, 1);
    chk("R8 no mask in single mode", n_mask, 0);

    // R3 R4: 8-bit immediate, high byte ignored, source fixed
    clr();
    mem[10'h111] = 8'h77;
    set_desc(16'h0012, 16'd1, 16'hAB5C, 16'h0000, 16'h0110);
    exp_w(1'b0, 16'h0110, 16'h005C); exp_wb(16'd0, 16'hAB5C, 16'h0000, 16'h0111);
    fire(); settle(40);
    drained("R4 immediate store");
    chk("R3 neighbour byte untouched", int'(mem[10'h111]), 8'h77);
    chk("R8 no irq when disabled", n_irq, 0);

    // R5: memory+memory add, wraps, operand advances with source
    clr();
    set_desc(16'h000D, 16'd2, 16'h0220, 16'h0240, 16'h0120);
    put_w(16'h0220, 16'hFFF0); put_w(16'h0222, 16'h0005);
    put_w(16'h0240, 16'h0020); put_w(16'h0242, 16'h0100);
    exp_w(1'b1, 16'h0120, 16'h0010); exp_wb(16'd1, 16'h0222, 16'h0242, 16'h0120);
    exp_w(1'b1, 16'h0120, 16'h0105); exp_wb(16'd0, 16'h0224, 16'h0244, 16'h0120);
    fire(); settle(40); fire(); settle(40);
    drained("R5 add memory+memory");

    // R6 R3: immediate + memory, 8-bit, wraps, no source/operand advance
    clr();
    set_desc(16'h005E, 16'd1, 16'h77F0, 16'h0250, 16'h0130);
    put_w(16'h0250, 16'h9930);
    exp_w(1'b0, 16'h0130, 16'h0020); exp_wb(16'd0, 16'h77F0, 16'h0250, 16'h0131);
    fire(); settle(40);
    drained("R6 add immediate+memory");
    chk("R6 irq_end", n_irq, 1);

    // R9: burst of 3
    clr();
    set_desc(16'h0079, 16'd3, 16'h0260, 16'h0000, 16'h0140);
    put_w(16'h0260, 16'h1111); put_w(16'h0262, 16'h2222); put_w(16'h0264, 16'h3333);
    exp_w(1'b1, 16'h0140, 16'h1111); exp_w(1'b1, 16'h0142, 16'h2222);
    exp_w(1'b1, 16'h0144, 16'h3333); exp_wb(16'd0, 16'h0266, 16'h0000, 16'h0146);
    fire(); settle(50);
    drained("R9 burst moves all units");
    chk("R9 irq_mask cycles", n_mask, 17);
    chk("R9 irq_end after burst", n_irq, 1);

    // R7: zero count
    clr();
    set_desc(16'h0059, 16'd0, 16'h0200, 16'h0000, 16'h0180);
    fire(); settle(30);
    drained("R7 zero count");
    chk("R7 no irq", n_irq, 0);

    // R10: multiple mode, N=2, add/burst/irq bits set but ignored
    clr();
    set_desc(16'h02E5, 16'd9, 16'h0270, 16'h0150, 16'h0272);
    put_w(16'h000A, 16'h0152);
    put_w(16'h0270, 16'hA1A1); put_w(16'h0272, 16'hB2B2);
    exp_w(1'b1, 16'h0150, 16'hA1A1); exp_w(1'b1, 16'h0152, 16'hB2B2);
    fire(); settle(40);
    drained("R10 multiple copies, no writeback");
    chk("R10 no irq", n_irq, 0);
    chk("R10 no mask", n_mask, 0);

    // R11: multiple mode with N=0
    clr();
    set_desc(16'h0081, 16'd1, 16'h0270, 16'h0160, 16'h0272);
    fire(); settle(30);
    drained("R11 no transfer");
    chk("R11 cfg_err pulse", n_err, 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R12: watchdog expired got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule